// File: doc/BRIEF.md
# Packet Timestamp Capture Latch

This block records the running system time when a timing-event packet crosses the MAC. There is one capture slot for the transmit direction and one for the receive direction. Each slot samples the time counter on the start-of-frame strobe of a packet that qualifies. It then locks. Software takes the value as two 32-bit words, the low word first and then the high word. Reading the high word frees the slot for the next packet.

A transmit packet qualifies when the datapath has marked it for timestamping. Receive packets are qualified by a filter that uses the classification fields the parser supplies: ethertype, UDP destination port, protocol version and message type. The filter has two modes:

- **Version-1 UDP mode** matches a single programmed message type.
- **Version-2 event mode** matches every event message, carried either over UDP or directly over Ethernet.

Ethernet-level capture also requires a programmed ethertype filter entry.

Top module: `ts_capture_latch`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero. This covers both control words (address 0 transmit, address 1 receive), both valid flags, the config words and the stored stamps.
- R2: In the transmit path, a capture happens when three things are true on the same cycle: the enable bit (bit 4 of address 0) is set, `tx_sof` is high and `tx_mark` is high. The capture stores `systime` from that cycle and sets the valid flag (bit 0 of address 0). The stamp reads back as bits 31:0 at address 4 and bits 63:32 at address 5.
- R3: While a direction's valid flag is set, further qualifying events in that direction are dropped, and the stored stamp does not change.
- R4: A read of the high word clears that direction's valid flag from the next cycle on, which frees the slot. Address 5 is the transmit high word and address 7 the receive high word. Reading a low word (address 4 or 6) changes nothing.
- R5: In the transmit path, a start-of-frame without `tx_mark`, or any packet while the transmit enable is off, captures nothing.
- R6: In receive mode 01 (bits 2:1 of address 1, enable in bit 4), a packet is captured only when all of these hold:
  - `rx_is_udp` is set;
  - `rx_dport` equals bits 31:16 of address 2;
  - `rx_ver` is 1;
  - `rx_msg` equals bits 7:0 of address 2.
  The stamp reads at addresses 6 and 7.
- R7: In receive mode 10, a packet is captured when `rx_ver` is 2 and `rx_msg` is in the range 0 to 3 (the event messages, peer-delay included). It must also arrive either over UDP with a matching port, or through the Ethernet-level path of R8. Message codes 4 and above are ignored.
- R8: The Ethernet-level path requires all of the following on the ethertype filter entry and the packet:
  - the entry at address 3 has its enable bit (bit 31) set;
  - the entry has its timestamp flag (bit 30) set;
  - the entry's ethertype (bits 15:0) is 0x88F7;
  - `rx_has_etype` is set and `rx_etype` equals that ethertype.
- R9: Writing a control word with bit 4 at zero clears both the enable bit and the receive mode field, whatever the other written bits are.
- R10: If a high-word read and a qualifying event in the same direction fall on one cycle, the event is dropped and the valid flag reads zero afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| systime | input | 64 | Running system time counter |
| tx_sof | input | 1 | Transmit start-of-frame strobe |
| tx_mark | input | 1 | Transmit packet is marked for timestamping |
| rx_sof | input | 1 | Receive start-of-frame strobe |
| rx_has_etype | input | 1 | Receive packet carries a classified ethertype |
| rx_etype | input | 16 | Receive ethertype |
| rx_is_udp | input | 1 | Receive packet is UDP |
| rx_dport | input | 16 | Receive UDP destination port |
| rx_ver | input | 4 | Timing protocol version of the receive packet |
| rx_msg | input | 8 | Message type of the receive packet |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (high-word reads have a side effect) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |

## Verification
Two actions can land on the same cycle: software's high-word read, which releases a slot, and a qualifying start-of-frame, which would fill it. The bench provokes this by driving an `rx_sof` that matches the filter in the same cycle as the read of the receive high word. It judges the result in two ways. The read must return the old stamp. Afterwards the control word must show the valid flag clear and the low word unchanged, which proves the coincident packet was dropped rather than captured.

// File: rtl/ts_cap_pkg.sv
// Shared definitions for the packet timestamp capture latch.
// Assumes a 32-bit register word and a time counter of two words.
package ts_cap_pkg;
    typedef enum logic [1:0] {
        RXM_OFF    = 2'b00,
        RXM_V1_UDP = 2'b01,
        RXM_V2_EVT = 2'b10,
        RXM_RSVD   = 2'b11
    } rx_mode_e;

    localparam logic [2:0] A_TXCTL  = 3'd0;
    localparam logic [2:0] A_RXCTL  = 3'd1;
    localparam logic [2:0] A_MSGCFG = 3'd2;
    localparam logic [2:0] A_ETQ    = 3'd3;
    localparam logic [2:0] A_TXLO   = 3'd4;
    localparam logic [2:0] A_TXHI   = 3'd5;
    localparam logic [2:0] A_RXLO   = 3'd6;
    localparam logic [2:0] A_RXHI   = 3'd7;

    localparam logic [15:0] PTP_ETYPE = 16'h88F7;
    localparam int          EN_BIT    = 4;
endpackage

// File: rtl/ts_rx_filter.sv
// Receive qualification filter: decides whether a classified packet is a
// timing event that the receive slot should capture.
// Assumes the classification fields are valid whenever the start strobe is.
module ts_rx_filter
    import ts_cap_pkg::*;
#(
    parameter int PORT_W = 16,
    parameter int MSG_W  = 8,
    parameter int VER_W  = 4
) (
    input  rx_mode_e          mode,
    input  logic [PORT_W-1:0] cfg_port,
    input  logic [MSG_W-1:0]  cfg_msg,
    input  logic              etq_en,
    input  logic              etq_ts,
    input  logic [15:0]       etq_type,
    input  logic              pkt_has_etype,
    input  logic [15:0]       pkt_etype,
    input  logic              pkt_is_udp,
    input  logic [PORT_W-1:0] pkt_dport,
    input  logic [VER_W-1:0]  pkt_ver,
    input  logic [MSG_W-1:0]  pkt_msg,
    output logic              hit
);
    localparam logic [VER_W-1:0] VER1 = VER_W'(1);
    localparam logic [VER_W-1:0] VER2 = VER_W'(2);

    logic udp_ok, l2_ok, evt_msg;

    // Transport checks shared by both modes.
    always_comb begin
        udp_ok  = pkt_is_udp && (pkt_dport == cfg_port);
        l2_ok   = pkt_has_etype && etq_en && etq_ts &&
                  (etq_type == PTP_ETYPE) && (pkt_etype == etq_type);
        evt_msg = (pkt_msg[MSG_W-1:2] == '0);
    end

    // Mode decode into the final match.
    always_comb begin
        case (mode)
            RXM_V1_UDP: hit = udp_ok && (pkt_ver == VER1) && (pkt_msg == cfg_msg);
            RXM_V2_EVT: hit = (udp_ok || l2_ok) && (pkt_ver == VER2) && evt_msg;
            default:    hit = 1'b0;
        endcase
    end

    // Any match must come from a packet of a supported version (R6, R7).
    always_comb begin
        if (hit) begin
            p_hit_version_r7: assert (pkt_ver == VER1 || pkt_ver == VER2);
        end
    end
endmodule

// File: rtl/ts_dir_latch.sv
// Single-entry capture slot for one direction. The slot samples the time on
// a qualifying event, locks, and is freed by a clear pulse. A clear wins
// over a coincident event.
// Assumes evt is already gated by the direction enable.
module ts_dir_latch #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt,
    input  logic              clr,
    input  logic [TIME_W-1:0] systime,
    output logic              valid,
    output logic [TIME_W-1:0] stamp
);
    // Capture, hold and release of the slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            stamp <= '0;
        end else if (clr) begin
            valid <= 1'b0;
        end else if (evt && !valid) begin
            valid <= 1'b1;
            stamp <= systime;
        end
    end

    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && evt && !clr) |=> (valid && stamp == $past(systime)));
    p_lock_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !clr) |=> (valid && $stable(stamp)));
    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !valid);
    p_coincident_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && evt) |=> (!valid && $stable(stamp)));
endmodule

// File: rtl/ts_capture_latch.sv
// Packet timestamp capture latch. It holds the configuration registers,
// qualifies transmit and receive start strobes, runs one capture slot per
// direction, and serves word reads. A read of a high word frees that slot.
// Assumes TIME_W is twice DATA_W and that reg_wr and reg_rd are exclusive.
module ts_capture_latch
    import ts_cap_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TIME_W = 64,
    parameter int PORT_W = 16,
    parameter int MSG_W  = 8,
    parameter int VER_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] systime,
    input  logic              tx_sof,
    input  logic              tx_mark,
    input  logic              rx_sof,
    input  logic              rx_has_etype,
    input  logic [15:0]       rx_etype,
    input  logic              rx_is_udp,
    input  logic [PORT_W-1:0] rx_dport,
    input  logic [VER_W-1:0]  rx_ver,
    input  logic [MSG_W-1:0]  rx_msg,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam int HI_W = TIME_W - DATA_W;
    localparam int DIRS = 2;
    localparam int TXI  = 0;
    localparam int RXI  = 1;

    logic              tx_en, rx_en;
    rx_mode_e          rx_mode;
    logic [PORT_W-1:0] cfg_port;
    logic [MSG_W-1:0]  cfg_msg;
    logic              etq_en, etq_ts;
    logic [15:0]       etq_type;
    logic              rx_hit;

    logic [DIRS-1:0]   evt, clr, vld;
    logic [TIME_W-1:0] stamp [DIRS];

    // Configuration register writes; clearing enable also clears the mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en    <= 1'b0;
            rx_en    <= 1'b0;
            rx_mode  <= RXM_OFF;
            cfg_port <= '0;
            cfg_msg  <= '0;
            etq_en   <= 1'b0;
            etq_ts   <= 1'b0;
            etq_type <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_TXCTL: tx_en <= reg_wdata[EN_BIT];
                A_RXCTL: begin
                    rx_en   <= reg_wdata[EN_BIT];
                    rx_mode <= reg_wdata[EN_BIT] ? rx_mode_e'(reg_wdata[2:1]) : RXM_OFF;
                end
                A_MSGCFG: begin
                    cfg_port <= reg_wdata[DATA_W-1 -: PORT_W];
                    cfg_msg  <= reg_wdata[MSG_W-1:0];
                end
                A_ETQ: begin
                    etq_en   <= reg_wdata[DATA_W-1];
                    etq_ts   <= reg_wdata[DATA_W-2];
                    etq_type <= reg_wdata[15:0];
                end
                default: ;
            endcase
        end
    end

    ts_rx_filter #(.PORT_W(PORT_W), .MSG_W(MSG_W), .VER_W(VER_W)) u_filter (
        .mode          (rx_mode),
        .cfg_port      (cfg_port),
        .cfg_msg       (cfg_msg),
        .etq_en        (etq_en),
        .etq_ts        (etq_ts),
        .etq_type      (etq_type),
        .pkt_has_etype (rx_has_etype),
        .pkt_etype     (rx_etype),
        .pkt_is_udp    (rx_is_udp),
        .pkt_dport     (rx_dport),
        .pkt_ver       (rx_ver),
        .pkt_msg       (rx_msg),
        .hit           (rx_hit)
    );

    // Per-direction event and high-word clear strobes.
    always_comb begin
        evt[TXI] = tx_en && tx_sof && tx_mark;
        evt[RXI] = rx_en && rx_sof && rx_hit;
        clr[TXI] = reg_rd && (reg_addr == A_TXHI);
        clr[RXI] = reg_rd && (reg_addr == A_RXHI);
    end

    for (genvar d = 0; d < DIRS; d++) begin : g_slot
        ts_dir_latch #(.TIME_W(TIME_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (evt[d]),
            .clr     (clr[d]),
            .systime (systime),
            .valid   (vld[d]),
            .stamp   (stamp[d])
        );
    end

    // Read data mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_TXCTL: begin
                reg_rdata[EN_BIT] = tx_en;
                reg_rdata[0]      = vld[TXI];
            end
            A_RXCTL: begin
                reg_rdata[EN_BIT] = rx_en;
                reg_rdata[2:1]    = rx_mode;
                reg_rdata[0]      = vld[RXI];
            end
            A_MSGCFG: begin
                reg_rdata[DATA_W-1 -: PORT_W] = cfg_port;
                reg_rdata[MSG_W-1:0]          = cfg_msg;
            end
            A_ETQ: begin
                reg_rdata[DATA_W-1] = etq_en;
                reg_rdata[DATA_W-2] = etq_ts;
                reg_rdata[15:0]     = etq_type;
            end
            A_TXLO:  reg_rdata = stamp[TXI][DATA_W-1:0];
            A_TXHI:  reg_rdata = stamp[TXI][TIME_W-1 -: HI_W];
            A_RXLO:  reg_rdata = stamp[RXI][DATA_W-1:0];
            default: reg_rdata = stamp[RXI][TIME_W-1 -: HI_W];
        endcase
    end

    p_disable_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_RXCTL && !reg_wdata[EN_BIT])
        |=> (!rx_en && rx_mode == RXM_OFF));
    p_tx_off_no_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !vld[TXI]) |=> !vld[TXI]);
endmodule

// File: tb/tb_ts_capture_latch.sv
// Scoreboard bench: the driver pushes expected register words into a queue,
// and a monitor pops and compares each one as its read is performed.
module tb_ts_capture_latch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] systime = 64'h0000_00A5_1234_0000;
    logic        tx_sof = 0, tx_mark = 0, rx_sof = 0;
    logic        rx_has_etype = 0, rx_is_udp = 0;
    logic [15:0] rx_etype = 0, rx_dport = 0;
    logic [3:0]  rx_ver = 0;
    logic [7:0]  rx_msg = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [2:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;

    int    n_tests = 0, n_fail = 0;
    logic  mon_go = 1'b0;
    bit    done = 1'b0;
    logic [31:0] exp_q[$];
    string tag_q[$];

    ts_capture_latch dut (
        .clk(clk), .rst_n(rst_n), .systime(systime),
        .tx_sof(tx_sof), .tx_mark(tx_mark), .rx_sof(rx_sof),
        .rx_has_etype(rx_has_etype), .rx_etype(rx_etype),
        .rx_is_udp(rx_is_udp), .rx_dport(rx_dport),
        .rx_ver(rx_ver), .rx_msg(rx_msg),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always #5 clk = ~clk;

    // Time counter advances away from the active edge.
    always @(negedge clk) systime <= systime + 64'h1_0000_0007;

    // Monitor: pops one expected word per read and compares.
    always @(negedge clk) begin
        #2;
        if (mon_go) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_tests++;
            if (reg_rdata !== e) begin
                n_fail++;
                $display("FAIL %s: addr %0d actual %h expected %h", t, reg_addr, reg_rdata, e);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 0;
    endtask

    task automatic rd_check(input logic [2:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(t);
        reg_rd = 1; reg_addr = a; mon_go = 1;
        @(posedge clk); #1;
        reg_rd = 0; mon_go = 0;
    endtask

    task automatic tx_pkt(input logic mark, output logic [63:0] t);
        @(negedge clk);
        tx_sof = 1; tx_mark = mark;
        #1 t = systime;
        @(posedge clk); #1;
        tx_sof = 0; tx_mark = 0;
    endtask

    task automatic set_rx(input logic het, input logic [15:0] et, input logic udp,
                          input logic [15:0] dp, input logic [3:0] v, input logic [7:0] m);
        rx_has_etype = het; rx_etype = et; rx_is_udp = udp;
        rx_dport = dp; rx_ver = v; rx_msg = m;
    endtask

    task automatic rx_pkt(input logic het, input logic [15:0] et, input logic udp,
                          input logic [15:0] dp, input logic [3:0] v, input logic [7:0] m,
                          output logic [63:0] t);
        @(negedge clk);
        set_rx(het, et, udp, dp, v, m);
        rx_sof = 1;
        #1 t = systime;
        @(posedge clk); #1;
        rx_sof = 0;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] t1, t2, tr, tl;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset state
        rd_check(3'd0, 32'h0, "R1");
        rd_check(3'd1, 32'h0, "R1");
        rd_check(3'd5, 32'h0, "R1");
        rd_check(3'd3, 32'h0, "R1");

        // R2 / R3 / R4: transmit capture, lock, release
        wr(3'd0, 32'h10);
        rd_check(3'd0, 32'h10, "R2");
        tx_pkt(1'b1, t1);
        rd_check(3'd0, 32'h11, "R2");
        rd_check(3'd4, t1[31:0], "R2");
        rd_check(3'd4, t1[31:0], "R4");
        rd_check(3'd0, 32'h11, "R4");
        tx_pkt(1'b1, t2);
        rd_check(3'd4, t1[31:0], "R3");
        rd_check(3'd5, t1[63:32], "R2");
        rd_check(3'd0, 32'h10, "R4");
        tx_pkt(1'b1, t2);
        rd_check(3'd4, t2[31:0], "R4");
        rd_check(3'd5, t2[63:32], "R4");

        // R5: unmarked and disabled transmit
        tx_pkt(1'b0, t1);
        rd_check(3'd0, 32'h10, "R5");
        wr(3'd0, 32'h0);
        tx_pkt(1'b1, t1);
        rd_check(3'd0, 32'h0, "R5");
        rd_check(3'd4, t2[31:0], "R5");

        // R6: version-1 UDP mode, port 319, message 0
        wr(3'd2, 32'h013F_0000);
        rd_check(3'd2, 32'h013F_0000, "R6");
        wr(3'd1, 32'h12);
        rd_check(3'd1, 32'h12, "R6");
        rx_pkt(0, 16'h0, 1, 16'd319, 4'd1, 8'd1, tr);
        rd_check(3'd1, 32'h12, "R6");
        rx_pkt(0, 16'h0, 1, 16'd320, 4'd1, 8'd0, tr);
        rd_check(3'd1, 32'h12, "R6");
        rx_pkt(0, 16'h0, 1, 16'd319, 4'd2, 8'd0, tr);
        rd_check(3'd1, 32'h12, "R6");
        rx_pkt(0, 16'h0, 1, 16'd319, 4'd1, 8'd0, tr);
        rd_check(3'd1, 32'h13, "R6");
        rx_pkt(0, 16'h0, 1, 16'd319, 4'd1, 8'd0, t1);
        rd_check(3'd6, tr[31:0], "R3");
        rd_check(3'd7, tr[63:32], "R6");
        rd_check(3'd1, 32'h12, "R4");

        // R7: version-2 event mode over UDP
        wr(3'd1, 32'h14);
        rx_pkt(0, 16'h0, 1, 16'd319, 4'd2, 8'd8, t1);
        rd_check(3'd1, 32'h14, "R7");
        rx_pkt(0, 16'h0, 1, 16'd319, 4'd2, 8'd2, tr);
        rd_check(3'd1, 32'h15, "R7");
        rd_check(3'd6, tr[31:0], "R7");
        rd_check(3'd7, tr[63:32], "R7");

        // R8: Ethernet-level path needs an enabled, flagged 0x88F7 entry
        rx_pkt(1, 16'h88F7, 0, 16'd0, 4'd2, 8'd0, t1);
        rd_check(3'd1, 32'h14, "R8");
        wr(3'd3, 32'h8000_88F7);
        rx_pkt(1, 16'h88F7, 0, 16'd0, 4'd2, 8'd0, t1);
        rd_check(3'd1, 32'h14, "R8");
        wr(3'd3, 32'hC000_88F7);
        rd_check(3'd3, 32'hC000_88F7, "R8");
        rx_pkt(1, 16'h88F6, 0, 16'd0, 4'd2, 8'd0, t1);
        rd_check(3'd1, 32'h14, "R8");
        rx_pkt(1, 16'h88F7, 0, 16'd0, 4'd2, 8'd3, tl);
        rd_check(3'd1, 32'h15, "R8");
        rd_check(3'd6, tl[31:0], "R8");
        rd_check(3'd7, tl[63:32], "R8");

        // R10: high-word read coincides with a qualifying event
        @(negedge clk);
        set_rx(1, 16'h88F7, 0, 16'd0, 4'd2, 8'd0);
        exp_q.push_back(tl[63:32]); tag_q.push_back("R10");
        reg_rd = 1; reg_addr = 3'd7; mon_go = 1; rx_sof = 1;
        @(posedge clk); #1;
        reg_rd = 0; mon_go = 0; rx_sof = 0;
        rd_check(3'd1, 32'h14, "R10");
        rd_check(3'd6, tl[31:0], "R10");

        // R9: disabling clears enable and mode
        wr(3'd1, 32'h04);
        rd_check(3'd1, 32'h0, "R9");
        rx_pkt(1, 16'h88F7, 0, 16'd0, 4'd2, 8'd0, t1);
        rd_check(3'd1, 32'h0, "R9");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule